// File: doc/BRIEF.md
# Display Panel Power Sequencer

This controller brings an RGB display panel from fully unpowered to running and back again. It owns the two supply enables (analog and I/O) and the panel reset line. Every command and parameter byte goes out through a byte-wide valid/ready port. A data/command flag marks each byte, and a read flag marks the commands that expect a reply byte. All waits are measured in periods of an external millisecond tick, so the block itself can run at any system clock.

A power-up request starts the full bring-up. The steps are:
- switch the supplies on and let them settle;
- pulse the panel reset;
- send the wake command twice and let the panel wake;
- send the vendor setup writes, wrapped in an unlock/lock password pair;
- read the three identification bytes.

The 89-byte stream of unlock, setup and lock bytes is produced by a small synchronous ROM whose contents are computed, not listed. Once the panel is powered, three single-command requests are served: display on, display off, and power down. Requests are single-cycle pulses. A `busy` flag covers each sequence and a one-cycle `done` pulse closes it.

Top module: `panel_pwr_seq`

## Requirements
- R1: After reset, `vci_en` and `vio_en` are 0, `panel_rst` is 1, `busy` is 0, `cmd_valid` is 0 and `id_valid` is 0.
- R2: A power-up request accepted in the off state raises both supply enables in the next cycle while reset stays asserted. `panel_rst` falls only after T_SUP_MS ticks and then T_RST_MS+1 further ticks. No byte is offered before T_BOOT_MS more ticks have passed, and no byte is ever offered while reset is asserted or the supplies are off.
- R3: The first two bytes of power-up are command 0x11 (dc=1), sent back to back. The next byte follows no earlier than T_WAKE_MS ticks after the second 0x11 is accepted.
- R4: The wake commands are followed by exactly 89 bytes, in this order:
  - command 0xF0 with data 0x5A, 0x5A (unlock);
  - command 0xB3 with data 0x22;
  - commands 0xB4 (8 data bytes, the last 0x0C), 0xF3 (7), 0xF2 (7, the last 0x3F), 0xF4 (10: 00 00 00 00 55 44 05 88 4B 50) and 0xF6 (6, the last 0x16);
  - command 0xF7 with 37 data bytes: 0x00, then twice the run 05 06 07 08 01 09 0D 0A 0E 0B 0F 0C 10 01 11 12 13 14;
  - command 0xF0 with data 0xA5, 0xA5 (lock).

  Command bytes carry `cmd_dc`=1 and data bytes `cmd_dc`=0.
- R5: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid`, `cmd_byte`, `cmd_dc` and `cmd_rd` hold their values. A byte is consumed only on a cycle with both high.
- R6: After the lock, commands 0xDA, 0xDB and 0xDC are sent in that order with `cmd_rd`=1 and `cmd_dc`=1. After each is accepted, the block waits for `rd_valid` or `rd_err`. When all three replies arrive, `panel_id` holds them with the 0xDA reply in bits 23:16 and the 0xDC reply in bits 7:0, and `id_valid` is 1.
- R7: A `rd_err` during the ID readout sends no further read command, leaves `id_valid` at 0 and finishes the power-up with the supplies on.
- R8: A display-on request in the powered state sends the single command 0x29 and then finishes.
- R9: A display-off request in the powered state sends command 0x28, and finishes no earlier than T_OFF_MS ticks after its acceptance.
- R10: A power-down request in the powered state sends command 0x10. No earlier than T_SLEEP_MS ticks later, it asserts `panel_rst`, and one cycle after that it clears both supply enables.
- R11: `busy` is 1 from the cycle after an accepted request until the sequence ends. `done` is a single-cycle pulse that arrives together with `busy` falling.
- R12: Requests that arrive while `busy` is 1 are ignored. A power-up request in the powered state is ignored, and the three other requests are ignored in the off state.
- R13: When several requests arrive together in the powered state, power-down wins over display-off, and display-off wins over display-on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| req_power_up | input | 1 | Request pulse: full bring-up |
| req_power_down | input | 1 | Request pulse: sleep and remove power |
| req_disp_on | input | 1 | Request pulse: display on |
| req_disp_off | input | 1 | Request pulse: display off |
| cmd_valid | output | 1 | Byte offered on the command port |
| cmd_ready | input | 1 | Command port accepts the byte |
| cmd_byte | output | 8 | Byte value |
| cmd_dc | output | 1 | 1 = command byte, 0 = parameter byte |
| cmd_rd | output | 1 | 1 = command expects one reply byte |
| rd_valid | input | 1 | Reply byte present on rd_data |
| rd_err | input | 1 | Reply failed |
| rd_data | input | 8 | Reply byte |
| vci_en | output | 1 | Analog supply enable |
| vio_en | output | 1 | I/O supply enable |
| panel_rst | output | 1 | Panel reset, 1 = asserted |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle end-of-sequence pulse |
| panel_id | output | 24 | Identification bytes, first reply on top |
| id_valid | output | 1 | All three ID replies received |

## Verification
The bench builds the block with short waits: 4 ticks of supply settling, 1 tick of reset, 3 ticks of boot, 6 ticks of wake, 2 ticks after display-off and 5 ticks after sleep. It pulses the tick every fourth clock. With these values a whole power-up with 94 stalled byte handshakes fits in a few hundred cycles. Because each wait is distinct, the bench can tell from tick counts which wait was applied where, or whether one was swapped or shortened. A stall pattern on `cmd_ready` exercises the hold rule, and a second power-up with a failing second read reaches the early-exit path of the ID readout.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

  localparam int unsigned ROM_LEN = 89;
  localparam int unsigned PAT_LEN = 18;

  localparam logic [7:0] OP_WAKE   = 8'h11;
  localparam logic [7:0] OP_SLEEP  = 8'h10;
  localparam logic [7:0] OP_DON    = 8'h29;
  localparam logic [7:0] OP_DOFF   = 8'h28;
  localparam logic [7:0] OP_IDBASE = 8'hDA;
  localparam logic [7:0] OP_KEY    = 8'hF0;

  typedef struct packed {
    logic       dc;
    logic [7:0] val;
  } seq_byte_t;

  function automatic seq_byte_t cmd_b(input logic [7:0] v);
    return '{dc: 1'b1, val: v};
  endfunction

  function automatic seq_byte_t dat_b(input logic [7:0] v);
    return '{dc: 1'b0, val: v};
  endfunction

  // repeated run inside the last setup write
  function automatic logic [7:0] pat_byte(input int unsigned k);
    int unsigned j;
    if (k < 4)                 return 8'(5 + k);
    else if (k == 4 || k == 13) return 8'h01;
    else if (k <= 12) begin
      j = k - 5;
      return j[0] ? 8'(8'h0D + j / 2) : 8'(8'h09 + j / 2);
    end
    return 8'(8'h11 + (k - 14));
  endfunction

  function automatic seq_byte_t setup_entry(input int unsigned i);
    case (i)
      0:  return cmd_b(8'hB3);
      1:  return dat_b(8'h22);
      2:  return cmd_b(8'hB4);
      3:  return dat_b(8'h00);
      4:  return dat_b(8'h02);
      5:  return dat_b(8'h03);
      6:  return dat_b(8'h04);
      7:  return dat_b(8'h05);
      8:  return dat_b(8'h08);
      9:  return dat_b(8'h00);
      10: return dat_b(8'h0C);
      11: return cmd_b(8'hF3);
      12: return dat_b(8'h01);
      13: return dat_b(8'h00);
      14: return dat_b(8'h00);
      15: return dat_b(8'h08);
      16: return dat_b(8'h08);
      17: return dat_b(8'h02);
      18: return dat_b(8'h00);
      19: return cmd_b(8'hF2);
      20: return dat_b(8'h19);
      21: return dat_b(8'h00);
      22: return dat_b(8'h08);
      23: return dat_b(8'h0D);
      24: return dat_b(8'h03);
      25: return dat_b(8'h41);
      26: return dat_b(8'h3F);
      27: return cmd_b(8'hF4);
      28: return dat_b(8'h00);
      29: return dat_b(8'h00);
      30: return dat_b(8'h00);
      31: return dat_b(8'h00);
      32: return dat_b(8'h55);
      33: return dat_b(8'h44);
      34: return dat_b(8'h05);
      35: return dat_b(8'h88);
      36: return dat_b(8'h4B);
      37: return dat_b(8'h50);
      38: return cmd_b(8'hF6);
      39: return dat_b(8'h03);
      40: return dat_b(8'h09);
      41: return dat_b(8'h8A);
      42: return dat_b(8'h00);
      43: return dat_b(8'h01);
      44: return dat_b(8'h16);
      45: return cmd_b(8'hF7);
      46: return dat_b(8'h00);
      default: return dat_b(pat_byte((i - 47) % PAT_LEN));
    endcase
  endfunction

  // unlock pair, setup writes, lock pair
  function automatic seq_byte_t rom_entry(input int unsigned a);
    if (a == 0)                 return cmd_b(OP_KEY);
    else if (a < 3)             return dat_b(8'h5A);
    else if (a == ROM_LEN - 3)  return cmd_b(OP_KEY);
    else if (a > ROM_LEN - 3)   return dat_b(8'hA5);
    return setup_entry(a - 3);
  endfunction

endpackage

// File: rtl/panel_seq_rom.sv
module panel_seq_rom
  import panel_seq_pkg::*;
#(
  parameter int unsigned AW = 7
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output seq_byte_t     q
);
  // registered read, no reset: maps onto a block-RAM style ROM
  always_ff @(posedge clk) q <= rom_entry(int'(addr));
endmodule

// File: rtl/panel_seq_timer.sv
module panel_seq_timer #(
  parameter int unsigned CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] len,
  input  logic          tick,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                     cnt_q <= '0;
    else if (start)              cnt_q <= len;
    else if (tick && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/panel_seq_tx.sv
module panel_seq_tx (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] ld_val,
  input  logic       ld_dc,
  input  logic       ld_rd,
  input  logic       ready,
  output logic       valid,
  output logic [7:0] val,
  output logic       dc,
  output logic       rd
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      val   <= '0;
      dc    <= 1'b0;
      rd    <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      val   <= ld_val;
      dc    <= ld_dc;
      rd    <= ld_rd;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import panel_seq_pkg::*;
#(
  parameter int unsigned T_SUP_MS   = 20,
  parameter int unsigned T_RST_MS   = 1,
  parameter int unsigned T_BOOT_MS  = 20,
  parameter int unsigned T_WAKE_MS  = 120,
  parameter int unsigned T_OFF_MS   = 25,
  parameter int unsigned T_SLEEP_MS = 120
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ms_tick,
  input  logic        req_power_up,
  input  logic        req_power_down,
  input  logic        req_disp_on,
  input  logic        req_disp_off,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [7:0]  cmd_byte,
  output logic        cmd_dc,
  output logic        cmd_rd,
  input  logic        rd_valid,
  input  logic        rd_err,
  input  logic [7:0]  rd_data,
  output logic        vci_en,
  output logic        vio_en,
  output logic        panel_rst,
  output logic        busy,
  output logic        done,
  output logic [23:0] panel_id,
  output logic        id_valid
);
  localparam int unsigned TCW = $clog2(T_SUP_MS + T_RST_MS + T_BOOT_MS + T_WAKE_MS
                                       + T_OFF_MS + T_SLEEP_MS + 2);
  localparam int unsigned RAW = $clog2(ROM_LEN);
  localparam logic [RAW-1:0] ROM_LAST = RAW'(ROM_LEN - 1);

  typedef enum logic [4:0] {
    ST_OFF, ST_ON, ST_SUP, ST_RSTH, ST_BOOT, ST_WAKE2, ST_WAKET, ST_WAKEW,
    ST_ROMF, ST_ROMS, ST_ROMN, ST_RDCMD, ST_RDW, ST_DOFFT, ST_DOFFW,
    ST_SLPT, ST_SLPW, ST_PDN, ST_TXW, ST_FIN
  } st_t;

  st_t            st, st_n, ret_st, ret_n;
  logic           sup_q, sup_n, rstp_q, rstp_n, done_n;
  logic [RAW-1:0] addr_q, addr_n;
  logic [1:0]     idx_q, idx_n;
  logic [23:0]    id_q, id_n;
  logic           idv_q, idv_n;

  logic           tx_load, tx_dc, tx_rd;
  logic [7:0]     tx_val;
  logic           tmr_start, tmr_exp;
  logic [TCW-1:0] tmr_len;
  seq_byte_t      rom_q;

  panel_seq_rom #(.AW(RAW)) u_rom (.clk(clk), .addr(addr_q), .q(rom_q));

  panel_seq_timer #(.CW(TCW)) u_tmr (
    .clk(clk), .rst(rst), .start(tmr_start), .len(tmr_len),
    .tick(ms_tick), .expired(tmr_exp)
  );

  panel_seq_tx u_tx (
    .clk(clk), .rst(rst), .load(tx_load), .ld_val(tx_val), .ld_dc(tx_dc),
    .ld_rd(tx_rd), .ready(cmd_ready), .valid(cmd_valid), .val(cmd_byte),
    .dc(cmd_dc), .rd(cmd_rd)
  );

  always_comb begin
    st_n      = st;
    ret_n     = ret_st;
    sup_n     = sup_q;
    rstp_n    = rstp_q;
    done_n    = 1'b0;
    addr_n    = addr_q;
    idx_n     = idx_q;
    id_n      = id_q;
    idv_n     = idv_q;
    tx_load   = 1'b0;
    tx_val    = '0;
    tx_dc     = 1'b1;
    tx_rd     = 1'b0;
    tmr_start = 1'b0;
    tmr_len   = '0;
    unique case (st)
      ST_OFF: if (req_power_up) begin
        sup_n     = 1'b1;
        rstp_n    = 1'b1;
        idv_n     = 1'b0;
        id_n      = '0;
        tmr_start = 1'b1;
        tmr_len   = TCW'(T_SUP_MS);
        st_n      = ST_SUP;
      end
      ST_SUP: if (tmr_exp) begin
        tmr_start = 1'b1;
        tmr_len   = TCW'(T_RST_MS + 1);
        st_n      = ST_RSTH;
      end
      ST_RSTH: if (tmr_exp) begin
        rstp_n    = 1'b0;
        tmr_start = 1'b1;
        tmr_len   = TCW'(T_BOOT_MS);
        st_n      = ST_BOOT;
      end
      ST_BOOT: if (tmr_exp) begin
        tx_load = 1'b1;
        tx_val  = OP_WAKE;
        ret_n   = ST_WAKE2;
        st_n    = ST_TXW;
      end
      ST_WAKE2: begin
        tx_load = 1'b1;
        tx_val  = OP_WAKE;
        ret_n   = ST_WAKET;
        st_n    = ST_TXW;
      end
      ST_WAKET: begin
        tmr_start = 1'b1;
        tmr_len   = TCW'(T_WAKE_MS);
        st_n      = ST_WAKEW;
      end
      ST_WAKEW: if (tmr_exp) begin
        addr_n = '0;
        st_n   = ST_ROMF;
      end
      ST_ROMF: st_n = ST_ROMS;
      ST_ROMS: begin
        tx_load = 1'b1;
        tx_val  = rom_q.val;
        tx_dc   = rom_q.dc;
        ret_n   = ST_ROMN;
        st_n    = ST_TXW;
      end
      ST_ROMN: begin
        if (addr_q == ROM_LAST) begin
          idx_n = '0;
          st_n  = ST_RDCMD;
        end else begin
          addr_n = addr_q + 1'b1;
          st_n   = ST_ROMF;
        end
      end
      ST_RDCMD: begin
        tx_load = 1'b1;
        tx_val  = OP_IDBASE + 8'(idx_q);
        tx_rd   = 1'b1;
        ret_n   = ST_RDW;
        st_n    = ST_TXW;
      end
      ST_RDW: begin
        if (rd_err) begin
          st_n = ST_FIN;
        end else if (rd_valid) begin
          id_n = {id_q[15:0], rd_data};
          if (idx_q == 2'd2) begin
            idv_n = 1'b1;
            st_n  = ST_FIN;
          end else begin
            idx_n = idx_q + 1'b1;
            st_n  = ST_RDCMD;
          end
        end
      end
      ST_ON: begin
        if (req_power_down) begin
          tx_load = 1'b1;
          tx_val  = OP_SLEEP;
          ret_n   = ST_SLPT;
          st_n    = ST_TXW;
        end else if (req_disp_off) begin
          tx_load = 1'b1;
          tx_val  = OP_DOFF;
          ret_n   = ST_DOFFT;
          st_n    = ST_TXW;
        end else if (req_disp_on) begin
          tx_load = 1'b1;
          tx_val  = OP_DON;
          ret_n   = ST_FIN;
          st_n    = ST_TXW;
        end
      end
      ST_DOFFT: begin
        tmr_start = 1'b1;
        tmr_len   = TCW'(T_OFF_MS);
        st_n      = ST_DOFFW;
      end
      ST_DOFFW: if (tmr_exp) st_n = ST_FIN;
      ST_SLPT: begin
        tmr_start = 1'b1;
        tmr_len   = TCW'(T_SLEEP_MS);
        st_n      = ST_SLPW;
      end
      ST_SLPW: if (tmr_exp) begin
        rstp_n = 1'b1;
        st_n   = ST_PDN;
      end
      ST_PDN: begin
        sup_n  = 1'b0;
        done_n = 1'b1;
        st_n   = ST_OFF;
      end
      ST_TXW: if (!cmd_valid) st_n = ret_st;
      ST_FIN: begin
        done_n = 1'b1;
        st_n   = ST_ON;
      end
      default: st_n = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_OFF;
      ret_st <= ST_OFF;
      sup_q  <= 1'b0;
      rstp_q <= 1'b1;
      done   <= 1'b0;
      addr_q <= '0;
      idx_q  <= '0;
      id_q   <= '0;
      idv_q  <= 1'b0;
    end else begin
      st     <= st_n;
      ret_st <= ret_n;
      sup_q  <= sup_n;
      rstp_q <= rstp_n;
      done   <= done_n;
      addr_q <= addr_n;
      idx_q  <= idx_n;
      id_q   <= id_n;
      idv_q  <= idv_n;
    end
  end

  assign vci_en    = sup_q;
  assign vio_en    = sup_q;
  assign panel_rst = rstp_q;
  assign busy      = (st != ST_OFF) && (st != ST_ON);
  assign panel_id  = id_q;
  assign id_valid  = idv_q;

endmodule

// File: rtl/panel_pwr_seq_chk.sv
module panel_pwr_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [7:0] cmd_byte,
  input logic       cmd_dc,
  input logic       cmd_rd,
  input logic       vci_en,
  input logic       vio_en,
  input logic       panel_rst,
  input logic       busy,
  input logic       done
);
  p_cmd_hold_r5: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_byte) && $stable(cmd_dc) && $stable(cmd_rd));

  p_no_cmd_in_reset_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !panel_rst && vci_en && vio_en);

  p_release_powered_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(panel_rst) |-> vci_en && vio_en);

  p_rst_before_off_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(vci_en) |-> panel_rst && $past(panel_rst));

  p_off_in_reset_r1: assert property (@(posedge clk) disable iff (rst)
    !vci_en |-> panel_rst);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && $past(busy));
endmodule

bind panel_pwr_seq panel_pwr_seq_chk u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_byte(cmd_byte), .cmd_dc(cmd_dc), .cmd_rd(cmd_rd), .vci_en(vci_en),
  .vio_en(vio_en), .panel_rst(panel_rst), .busy(busy), .done(done)
);

// File: tb/panel_pwr_seq_bench.sv
`timescale 1ns/1ps
module panel_pwr_seq_bench;
  localparam int P_SUP = 4, P_RST = 1, P_BOOT = 3, P_WAKE = 6, P_OFF = 2, P_SLEEP = 5;
  localparam int TICK_DIV = 4;
  localparam int NVEC = 31;
  // {log position, rd flag, dc flag, byte}
  localparam logic [17:0] VEC [NVEC] = '{
    {8'd0,  2'b01, 8'h11}, {8'd1,  2'b01, 8'h11}, {8'd2,  2'b01, 8'hF0},
    {8'd3,  2'b00, 8'h5A}, {8'd4,  2'b00, 8'h5A}, {8'd5,  2'b01, 8'hB3},
    {8'd6,  2'b00, 8'h22}, {8'd7,  2'b01, 8'hB4}, {8'd15, 2'b00, 8'h0C},
    {8'd16, 2'b01, 8'hF3}, {8'd24, 2'b01, 8'hF2}, {8'd31, 2'b00, 8'h3F},
    {8'd32, 2'b01, 8'hF4}, {8'd37, 2'b00, 8'h55}, {8'd42, 2'b00, 8'h50},
    {8'd43, 2'b01, 8'hF6}, {8'd49, 2'b00, 8'h16}, {8'd50, 2'b01, 8'hF7},
    {8'd51, 2'b00, 8'h00}, {8'd52, 2'b00, 8'h05}, {8'd57, 2'b00, 8'h09},
    {8'd58, 2'b00, 8'h0D}, {8'd69, 2'b00, 8'h14}, {8'd70, 2'b00, 8'h05},
    {8'd87, 2'b00, 8'h14}, {8'd88, 2'b01, 8'hF0}, {8'd89, 2'b00, 8'hA5},
    {8'd90, 2'b00, 8'hA5}, {8'd91, 2'b11, 8'hDA}, {8'd92, 2'b11, 8'hDB},
    {8'd93, 2'b11, 8'hDC}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ms_tick = 1'b0;
  logic req_power_up = 1'b0, req_power_down = 1'b0, req_disp_on = 1'b0, req_disp_off = 1'b0;
  logic cmd_valid, cmd_ready = 1'b0, cmd_dc, cmd_rd;
  logic [7:0] cmd_byte;
  logic rd_valid = 1'b0, rd_err = 1'b0;
  logic [7:0] rd_data = '0;
  logic vci_en, vio_en, panel_rst, busy, done, id_valid;
  logic [23:0] panel_id;

  always #2 clk = ~clk;

  panel_pwr_seq #(
    .T_SUP_MS(P_SUP), .T_RST_MS(P_RST), .T_BOOT_MS(P_BOOT),
    .T_WAKE_MS(P_WAKE), .T_OFF_MS(P_OFF), .T_SLEEP_MS(P_SLEEP)
  ) u_panel_pwr_seq (
    .clk(clk), .rst(rst), .ms_tick(ms_tick),
    .req_power_up(req_power_up), .req_power_down(req_power_down),
    .req_disp_on(req_disp_on), .req_disp_off(req_disp_off),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_byte(cmd_byte),
    .cmd_dc(cmd_dc), .cmd_rd(cmd_rd), .rd_valid(rd_valid), .rd_err(rd_err),
    .rd_data(rd_data), .vci_en(vci_en), .vio_en(vio_en), .panel_rst(panel_rst),
    .busy(busy), .done(done), .panel_id(panel_id), .id_valid(id_valid)
  );

  int n_chk = 0, n_err = 0;
  int cyc = 0, tick_cnt = 0;
  logic [9:0] blog [256];
  int acc_tick [256];
  int log_n = 0;
  int done_cnt = 0, done_tick = 0;
  int sup_rise_tick = 0, rst_fall_tick = 0, rst_rise_tick = 0;
  int rst_rise_cyc = 0, sup_fall_cyc = 0;
  int rd_cd = 0, rd_n = 0, err_at = -1;
  int unstable = 0;
  logic prev_vci = 1'b0, prev_rst = 1'b1, pend = 1'b0;
  logic [7:0] pend_b = '0;

  function automatic logic [7:0] id_reply(input int n);
    case (n % 3)
      0: return 8'h3C;
      1: return 8'h91;
      default: return 8'h07;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor and responder, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (vci_en && !prev_vci) sup_rise_tick = tick_cnt;
    if (!vci_en && prev_vci) sup_fall_cyc = cyc;
    if (!panel_rst && prev_rst) rst_fall_tick = tick_cnt;
    if (panel_rst && !prev_rst) begin
      rst_rise_cyc = cyc;
      rst_rise_tick = tick_cnt;
    end
    if (done) begin
      done_cnt++;
      done_tick = tick_cnt;
    end
    prev_vci = vci_en;
    prev_rst = panel_rst;
    if (pend && cmd_valid && cmd_byte != pend_b) unstable++;
    rd_valid = 1'b0;
    rd_err = 1'b0;
    if (rd_cd > 0) begin
      rd_cd--;
      if (rd_cd == 0) begin
        if (rd_n == err_at) rd_err = 1'b1;
        else begin
          rd_valid = 1'b1;
          rd_data = id_reply(rd_n);
        end
        rd_n++;
      end
    end
    cmd_ready = (cyc % 3) != 1;
    if (cmd_valid && cmd_ready && log_n < 256) begin
      blog[log_n] = {cmd_rd, cmd_dc, cmd_byte};
      acc_tick[log_n] = tick_cnt;
      if (cmd_rd) rd_cd = 3;
      log_n++;
    end
    pend = cmd_valid && !cmd_ready;
    pend_b = cmd_byte;
    ms_tick = (cyc % TICK_DIV) == 0;
    if (ms_tick) tick_cnt++;
  end

  task automatic pulse(input bit up, input bit dn, input bit on, input bit off);
    @(negedge clk);
    req_power_up = up; req_power_down = dn; req_disp_on = on; req_disp_off = off;
    @(negedge clk);
    req_power_up = 0; req_power_down = 0; req_disp_on = 0; req_disp_off = 0;
  endtask

  task automatic wait_done(input string req);
    int start = done_cnt;
    int guard = 0;
    while (done_cnt == start && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    chk(done_cnt != start, req, 0, 1);
  endtask

  initial begin : main
    int base;
    int t0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!vci_en && !vio_en, "R1 supplies", {vci_en, vio_en}, 0);
    chk(panel_rst && !busy && !cmd_valid && !id_valid, "R1 rst/busy/valid/id",
        {panel_rst, busy, cmd_valid, id_valid}, 4'b1000);

    // R12 requests other than power-up are ignored while off
    base = log_n;
    pulse(0, 1, 1, 1);
    repeat (20) @(negedge clk);
    chk(log_n == base && !busy && !vci_en, "R12 off-state requests", log_n - base, 0);

    // power-up, with a stray request while busy (R12)
    base = log_n;
    pulse(1, 0, 0, 0);
    chk(busy && vci_en && vio_en && panel_rst, "R2/R11 supplies on, reset held, busy",
        {busy, vci_en, vio_en, panel_rst}, 4'hF);
    repeat (30) @(negedge clk);
    pulse(0, 1, 0, 1);
    wait_done("R11 power-up done");
    chk(log_n - base == 94, "R4/R12 power-up byte count", log_n - base, 94);
    chk(vci_en && !panel_rst && !busy, "R12 still powered", {vci_en, panel_rst, busy}, 3'b100);
    for (int v = 0; v < NVEC; v++) begin
      chk(blog[base + int'(VEC[v][17:10])] == VEC[v][9:0], "R3/R4/R6 byte vector",
          blog[base + int'(VEC[v][17:10])], VEC[v][9:0]);
    end
    begin
      int bad = 0;
      for (int k = 0; k < 91; k++) if (blog[base + k][9]) bad++;
      chk(bad == 0, "R6 rd flag only on ID reads", bad, 0);
    end
    chk(rst_fall_tick - sup_rise_tick >= P_SUP + P_RST + 1 &&
        rst_fall_tick - sup_rise_tick <= P_SUP + P_RST + 2, "R2 supply+reset wait",
        rst_fall_tick - sup_rise_tick, P_SUP + P_RST + 1);
    chk(acc_tick[base] - rst_fall_tick >= P_BOOT, "R2 boot wait",
        acc_tick[base] - rst_fall_tick, P_BOOT);
    chk(acc_tick[base + 2] - acc_tick[base + 1] >= P_WAKE, "R3 wake wait",
        acc_tick[base + 2] - acc_tick[base + 1], P_WAKE);
    chk(panel_id == 24'h3C9107 && id_valid, "R6 ID bytes", panel_id, 24'h3C9107);
    chk(unstable == 0, "R5 byte held while stalled", unstable, 0);

    // R8 display on
    base = log_n;
    pulse(0, 0, 1, 0);
    wait_done("R8 display on done");
    chk(log_n - base == 1 && blog[base] == 10'h129, "R8 display on byte", blog[base], 10'h129);

    // R13 display-off beats display-on; R9 wait
    base = log_n;
    pulse(0, 0, 1, 1);
    wait_done("R9 display off done");
    chk(log_n - base == 1 && blog[base] == 10'h128, "R13 off wins over on", blog[base], 10'h128);
    chk(done_tick - acc_tick[base] >= P_OFF, "R9 off wait", done_tick - acc_tick[base], P_OFF);

    // R12 power-up ignored while on
    base = log_n;
    pulse(1, 0, 0, 0);
    repeat (20) @(negedge clk);
    chk(log_n == base && !busy, "R12 power-up while on", log_n - base, 0);

    // R13 power-down beats display-off; R10 sequence
    base = log_n;
    pulse(0, 1, 0, 1);
    wait_done("R10 power-down done");
    chk(log_n - base == 1 && blog[base] == 10'h110, "R13 power-down wins", blog[base], 10'h110);
    chk(rst_rise_tick - acc_tick[base] >= P_SLEEP, "R10 sleep wait",
        rst_rise_tick - acc_tick[base], P_SLEEP);
    chk(sup_fall_cyc == rst_rise_cyc + 1, "R10 reset one cycle before supplies off",
        sup_fall_cyc - rst_rise_cyc, 1);
    chk(!vci_en && !vio_en && panel_rst && !busy, "R10 off state",
        {vci_en, vio_en, panel_rst, busy}, 4'b0010);

    // R7 second read fails
    err_at = rd_n + 1;
    base = log_n;
    pulse(1, 0, 0, 0);
    wait_done("R7 power-up with read error done");
    chk(log_n - base == 93, "R7 readout stops", log_n - base, 93);
    chk(blog[base + 92] == 10'h3DB, "R7 last read is second ID", blog[base + 92], 10'h3DB);
    chk(!id_valid && vci_en && !busy, "R7 id_valid low, powered", {id_valid, vci_en, busy}, 3'b010);
    t0 = log_n;
    repeat (20) @(negedge clk);
    chk(log_n == t0, "R7 no further reads", log_n - t0, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule